// File: doc/BRIEF.md
# Address-Bus Master Request and Qualified Grant

This block sits inside one master on a shared, split-transaction address bus. It turns a request from the local core into an active-low bus request toward an external arbiter. It then decides, cycle by cycle, whether the grant it sees may be used. A grant is usable only when four things hold. The grant line is low. No address retry is on the bus in the current cycle or the one before. No master is starting a transfer. The master has no address tenure of its own still open. The end-of-address acknowledge has no say in that decision.

When the grant is usable, the block raises a one-cycle `qualGrant` strobe. On the next cycle it drives its transfer-start line low for exactly one cycle. It keeps its own address tenure open until the cycle after the acknowledge. If a retry lands inside that window, it requests the bus again, but only once the retry has left its one-cycle history. With bus parking enabled, a master that already holds the grant may start in the same cycle that the core asks, without raising a request first.

Top module: `mbq_top`

## Requirements
- R1: After synchronous reset, brN and tsOutN are high and qualGrant is low. The retry history is clear, so a grant may qualify in the first cycle after reset.
- R2: A high needBus in one cycle makes a request pending. From the next cycle brN is low and stays low until the cycle after the qualGrant that consumes it. brN also stays high in any cycle whose previous cycle sampled artryN low.
- R3: qualGrant is high in a cycle only when all of the following hold. A request is wanted. bgN is low. artryN is high. tsInN is high. tsOutN is high. No own tenure is open.
- R4: If artryN was low in the previous cycle, qualGrant stays low even when every current input allows it.
- R5: tsInN low, meaning another master is starting a transfer, keeps qualGrant low in that cycle.
- R6: tsOutN goes low in the cycle after qualGrant and is high again one cycle later.
- R7: A qualGrant consumes one pending request. If needBus is high in the grant cycle while an earlier request was already pending, brN stays low for the new request. Otherwise brN returns high in the cycle tsOutN is low.
- R8: The own tenure runs from the tsOutN cycle through the cycle after the one in which aackN is low. If artryN is low anywhere in that window, the master re-requests. brN goes low again only in the cycle after artryN is first sampled high again.
- R9: With PARK_EN=1, needBus high together with a usable grant gives qualGrant in that same cycle, with brN never going low.
- R10: aackN has no effect on qualGrant while no own tenure is open.
- R11: While an own tenure is open, qualGrant stays low even with bgN low and a request pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising-edge sampling |
| rst | input | 1 | Synchronous active-high reset |
| needBus | input | 1 | Core asks for one address tenure |
| bgN | input | 1 | Bus grant from arbiter, active low |
| artryN | input | 1 | Address retry on the bus, active low |
| tsInN | input | 1 | Transfer start seen on the bus from other masters, active low |
| aackN | input | 1 | Address acknowledge ending a tenure, active low |
| brN | output | 1 | Bus request to arbiter, active low |
| tsOutN | output | 1 | This master's transfer start, active low |
| qualGrant | output | 1 | One-cycle strobe: the grant has qualified |

## Verification
The bench sets up a retry in one cycle followed by a grant in the next. A design that checks only the current retry value would start a tenure there. It also overlaps a foreign transfer start with a grant, which a design ignoring the bus start line would accept. It drives retries inside the master's own tenure and checks that the request returns exactly one cycle after the retry clears: a design that forgot the history would request too early, and one that lost the retry would never request. It places a second core request in the grant cycle, a parked start, acknowledges outside a tenure, and grants while a tenure is open. These catch lost requests, a wrongly asserted request line, an acknowledge leaking into qualification, and overlapping tenures.

// File: rtl/mbq_pkg.sv
package mbq_pkg;
  typedef struct packed {
    logic launch;     // grant qualified and used this cycle
    logic reqActive;  // a registered request is waiting
  } mbqStrobe_t;

  typedef enum logic [1:0] {
    TEN_IDLE = 2'd0,
    TEN_ADDR = 2'd1,
    TEN_WIN  = 2'd2
  } tenure_e;
endpackage

// File: rtl/mbq_datapath.sv
module mbq_datapath
  import mbq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bgN,
  input  logic       artryN,
  input  logic       tsInN,
  input  mbqStrobe_t strobe,
  output logic       busOk,
  output logic       brN,
  output logic       tsOutN
);
  logic artryLat;
  logic tsOutQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      artryLat <= 1'b0;
      tsOutQ   <= 1'b1;
    end else begin
      artryLat <= ~artryN;
      tsOutQ   <= ~strobe.launch;
    end
  end

  // grant usable: granted, no retry now or last cycle, no start by anyone
  assign busOk  = ~bgN & artryN & ~artryLat & tsInN & tsOutQ;
  assign brN    = ~(strobe.reqActive & ~artryLat);
  assign tsOutN = tsOutQ;
endmodule

// File: rtl/mbq_control.sv
module mbq_control
  import mbq_pkg::*;
#(
  parameter bit PARK_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       needBus,
  input  logic       aackN,
  input  logic       artryN,
  input  logic       busOk,
  output mbqStrobe_t strobe,
  output logic       qualGrant
);
  tenure_e state;
  logic    reqPend;
  logic    retryPend;
  logic    want;
  logic    fire;

  generate
    if (PARK_EN) begin : g_park
      assign want = reqPend | retryPend | needBus;
    end else begin : g_noPark
      assign want = reqPend | retryPend;
    end
  endgenerate

  assign fire = want & busOk & (state == TEN_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= TEN_IDLE;
      reqPend   <= 1'b0;
      retryPend <= 1'b0;
    end else begin
      if (fire) begin
        if (retryPend) begin
          retryPend <= 1'b0;
          reqPend   <= reqPend | needBus;
        end else if (reqPend) begin
          reqPend <= needBus;
        end else begin
          reqPend <= 1'b0;
        end
      end else begin
        reqPend <= reqPend | needBus;
      end

      case (state)
        TEN_IDLE: if (fire) state <= TEN_ADDR;
        TEN_ADDR: begin
          if (!artryN) begin
            retryPend <= 1'b1;
            state     <= TEN_IDLE;
          end else if (!aackN) begin
            state <= TEN_WIN;
          end
        end
        TEN_WIN: begin
          if (!artryN) retryPend <= 1'b1;
          state <= TEN_IDLE;
        end
        default: state <= TEN_IDLE;
      endcase
    end
  end

  assign strobe.launch    = fire;
  assign strobe.reqActive = reqPend | retryPend;
  assign qualGrant        = fire;
endmodule

// File: rtl/mbq_top.sv
module mbq_top
  import mbq_pkg::*;
#(
  parameter bit PARK_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic needBus,
  input  logic bgN,
  input  logic artryN,
  input  logic tsInN,
  input  logic aackN,
  output logic brN,
  output logic tsOutN,
  output logic qualGrant
);
  mbqStrobe_t strobe;
  logic       busOk;

  mbq_control #(.PARK_EN(PARK_EN)) u_ctl (
    .clk(clk), .rst(rst), .needBus(needBus), .aackN(aackN),
    .artryN(artryN), .busOk(busOk), .strobe(strobe), .qualGrant(qualGrant)
  );

  mbq_datapath u_dp (
    .clk(clk), .rst(rst), .bgN(bgN), .artryN(artryN), .tsInN(tsInN),
    .strobe(strobe), .busOk(busOk), .brN(brN), .tsOutN(tsOutN)
  );
endmodule

// File: rtl/mbq_checker.sv
module mbq_checker (
  input logic clk,
  input logic rst,
  input logic bgN,
  input logic artryN,
  input logic tsInN,
  input logic brN,
  input logic tsOutN,
  input logic qualGrant
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (rst) sinceRst <= 2'd0;
    else if (sinceRst != 2'd2) sinceRst <= sinceRst + 2'd1;
  end

  AST_TS_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
    (!tsOutN && sinceRst != 2'd0) |-> $past(!bgN && artryN && tsInN)); // R3
  AST_TS_NO_PRIOR_ARTRY: assert property (@(posedge clk) disable iff (rst)
    (!tsOutN && sinceRst == 2'd2) |-> $past(artryN, 2)); // R4
  AST_FOREIGN_TS_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    !tsInN |-> !qualGrant); // R5
  AST_GRANT_THEN_TS: assert property (@(posedge clk) disable iff (rst)
    qualGrant |=> !tsOutN); // R6
  AST_TS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !tsOutN |=> tsOutN); // R6
  AST_BR_WAITS_ARTRY: assert property (@(posedge clk) disable iff (rst)
    !artryN |=> brN); // R8
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !tsOutN |-> !qualGrant); // R11
endmodule

bind mbq_top mbq_checker u_chk (
  .clk(clk), .rst(rst), .bgN(bgN), .artryN(artryN), .tsInN(tsInN),
  .brN(brN), .tsOutN(tsOutN), .qualGrant(qualGrant)
);

// File: tb/sim_mbq_top.sv
module sim_mbq_top;
  localparam int PERIOD = 10;

  typedef struct {
    logic  qg;
    logic  br;
    logic  ts;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic needBus = 1'b0, bgN = 1'b1, artryN = 1'b1, tsInN = 1'b1, aackN = 1'b1;
  logic brN, tsOutN, qualGrant;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  expItem_t expQ[$];

  always #(PERIOD/2) clk = ~clk;

  mbq_top u0 (
    .clk(clk), .rst(rst), .needBus(needBus), .bgN(bgN), .artryN(artryN),
    .tsInN(tsInN), .aackN(aackN), .brN(brN), .tsOutN(tsOutN), .qualGrant(qualGrant)
  );

  // driver: set one cycle of inputs at the falling edge and queue expectations
  task automatic cyc(input logic nd, input logic bg, input logic ar, input logic ts,
                     input logic ak, input logic eQg, input logic eBr, input logic eTs,
                     input string tag);
    expItem_t it;
    @(negedge clk);
    needBus = nd; bgN = bg; artryN = ar; tsInN = ts; aackN = ak;
    it.qg = eQg; it.br = eBr; it.ts = eTs; it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: compare shortly after the falling edge
  always @(negedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (qualGrant !== it.qg || brN !== it.br || tsOutN !== it.ts) begin
        errors++;
        $display("FAIL %s: qualGrant/brN/tsOutN got %b%b%b expected %b%b%b",
                 it.tag, qualGrant, brN, tsOutN, it.qg, it.br, it.ts);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    //   nd bg ar ts ak  qg br ts
    cyc(0, 1, 1, 1, 1,  0, 1, 1, "R1 reset state");
    // basic request and grant
    cyc(1, 1, 1, 1, 1,  0, 1, 1, "R2 request cycle");
    cyc(0, 1, 1, 1, 1,  0, 0, 1, "R2 BR asserted");
    cyc(0, 0, 1, 1, 1,  1, 0, 1, "R3 qualified");
    cyc(0, 0, 1, 1, 1,  0, 1, 0, "R6 R7 TS and BR release");
    cyc(0, 0, 1, 1, 0,  0, 1, 1, "R6 TS back high, R11 tenure");
    cyc(0, 0, 1, 1, 1,  0, 1, 1, "R11 window");
    cyc(0, 0, 1, 1, 1,  0, 1, 1, "R3 no want");
    // retry history blocks, then retry of own tenure
    cyc(1, 0, 0, 1, 1,  0, 1, 1, "R3 current ARTRY");
    cyc(0, 0, 1, 1, 1,  0, 1, 1, "R4 previous ARTRY");
    cyc(0, 0, 1, 1, 1,  1, 0, 1, "R4 cleared");
    cyc(0, 1, 1, 1, 1,  0, 1, 0, "R6 TS");
    cyc(0, 1, 1, 1, 0,  0, 1, 1, "R8 AACK");
    cyc(0, 1, 0, 1, 1,  0, 1, 1, "R8 ARTRY in window");
    cyc(0, 1, 1, 1, 1,  0, 1, 1, "R8 BR held off");
    cyc(0, 1, 1, 1, 1,  0, 0, 1, "R8 BR reasserted");
    cyc(0, 0, 1, 1, 1,  1, 0, 1, "R8 regrant");
    cyc(0, 0, 1, 1, 0,  0, 1, 0, "R8 retry consumed");
    cyc(0, 1, 1, 1, 1,  0, 1, 1, "R8 window");
    // foreign transfer start
    cyc(1, 0, 1, 0, 1,  0, 1, 1, "R5 foreign TS");
    cyc(0, 0, 1, 1, 1,  1, 0, 1, "R5 after foreign TS");
    cyc(0, 1, 1, 1, 0,  0, 1, 0, "R6 TS");
    cyc(0, 1, 1, 1, 1,  0, 1, 1, "R11 window");
    // parked start
    cyc(1, 0, 1, 1, 1,  1, 1, 1, "R9 parked");
    cyc(0, 0, 1, 1, 0,  0, 1, 0, "R9 no BR");
    cyc(0, 1, 1, 1, 1,  0, 1, 1, "R9 window");
    // second request in grant cycle
    cyc(1, 1, 1, 1, 1,  0, 1, 1, "R7 first request");
    cyc(1, 0, 1, 1, 1,  1, 0, 1, "R7 grant with new request");
    cyc(0, 1, 1, 1, 0,  0, 0, 0, "R7 BR kept");
    cyc(0, 1, 1, 1, 1,  0, 0, 1, "R7 window");
    cyc(0, 0, 1, 1, 1,  1, 0, 1, "R7 second grant");
    cyc(0, 1, 1, 1, 0,  0, 1, 0, "R7 BR released");
    cyc(0, 1, 1, 1, 1,  0, 1, 1, "R7 window");
    // AACK outside tenure, grant during open tenure
    cyc(1, 1, 1, 1, 0,  0, 1, 1, "R10 request");
    cyc(0, 0, 1, 1, 0,  1, 0, 1, "R10 AACK ignored");
    cyc(1, 0, 1, 1, 1,  0, 1, 0, "R11 TS cycle");
    cyc(0, 0, 1, 1, 0,  0, 0, 1, "R11 open tenure");
    cyc(0, 0, 1, 1, 1,  0, 0, 1, "R11 window");
    cyc(0, 0, 1, 1, 1,  1, 0, 1, "R11 after tenure");
    cyc(0, 1, 1, 1, 0,  0, 1, 0, "R6 TS");
    cyc(0, 1, 1, 1, 1,  0, 1, 1, "R11 window");
    cyc(0, 1, 1, 1, 1,  0, 1, 1, "R1 idle again");
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule